// File: doc/BRIEF.md
# Sample Fetch DMA with CPU Stall

This block supplies sample bytes to the level counter of a delta-modulated audio channel by borrowing cycles from the CPU's bus. Software writes a start-address register, a length register and an enable bit in the channel control register. After that, playback runs by itself. The block raises a fetch request whenever the level counter's one-byte buffer is empty and bytes remain. It pulls the CPU's ready input low and waits until the CPU is in a read cycle, because the CPU ignores ready while it is writing. It then holds the stall for a fixed number of read cycles. On the last of these cycles it puts its own sample address on the bus and captures the returned byte.

The CPU stays halted on its read for the whole stall, and its read address stays on the bus. A peripheral decoding that address therefore sees the same read several times. The block reports how many such repeated presentations happened during the current or most recent stall. Each captured byte is handed to the level counter with a one-cycle valid strobe. After each byte the sample address steps by one and the remaining count drops by one.

Top module: `sample_fetch_dma`

## Requirements
- R1: While reset is asserted and right after it, `cpu_rdy` is 1, `byte_valid` is 0, `rpt_cnt` is 0, and the bus outputs follow the CPU inputs.
- R2: Writing the control register (default address 16'h4015) with bit 4 set loads the cursor, but only if the remaining count is zero. The start address becomes 16'hC000 + 64 × (start register, 16'h4012). The count becomes 16 × (length register, 16'h4013) + 1. If bytes remain, the position is kept.
- R3: No stall starts unless the channel is enabled, `buf_empty` is 1 and the remaining count is non-zero. A control write with bit 4 clear disables the channel.
- R4: A fetch request drives `cpu_rdy` low from the next cycle on. When the CPU is reading throughout, `cpu_rdy` stays low for exactly 4 cycles.
- R5: Stall cycles in which the CPU issues a write (`cpu_rw` = 0) are not counted. Each such write lengthens the low period of `cpu_rdy` by one cycle.
- R6: On the last stall cycle, `bus_addr` carries the sample address and `bus_rw` is 1. In the next cycle, `byte_valid` is 1 for one cycle, and `byte_data` holds the byte read in that last stall cycle.
- R7: Each fetched byte advances the sample address by one and lowers the remaining count by one. Once the count is zero, no further stall occurs.
- R8: Clearing the enable bit during a stall lets that stall finish and deliver its byte. No new stall follows.
- R9: `rpt_cnt` is cleared when a stall begins. It counts the stall cycles, other than the final fetch cycle, in which the CPU's read address was held on the bus. A pure read stall gives 3.
- R10: Outside the final stall cycle, `bus_addr` equals `cpu_addr` and `bus_rw` equals `cpu_rw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Address driven by the CPU |
| cpu_rw | input | 1 | CPU cycle type, 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data, used for register writes |
| cpu_rdy | output | 1 | Ready to the CPU, low while stalling |
| bus_addr | output | 16 | Address presented to memory and peripherals |
| bus_rw | output | 1 | Cycle type presented to memory and peripherals |
| bus_rdata | input | 8 | Read data returned from the bus |
| buf_empty | input | 1 | Level counter's sample buffer is empty |
| byte_valid | output | 1 | One-cycle strobe, fetched byte available |
| byte_data | output | 8 | Fetched sample byte |
| rpt_cnt | output | 3 | Repeated presentations of the stalled CPU read address |

## Verification
The fetch path is exercised under three CPU patterns, each separating a different behaviour. In the first, the CPU reads continuously, which fixes the bare stall length and the repeat count of three. In the second, the CPU issues two writes just as the stall begins, which shows that write cycles stretch the stall instead of being consumed by it. In the third, the CPU's write inside a stall disables the channel, which separates finishing the current fetch from starting a new one. Runs with a one-byte length and with a reload attempt while bytes remain tell count exhaustion apart from cursor retention.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_STALL = 1'b1
   } stall_st_e;

endpackage

// File: rtl/sfd_regs.sv
// Register decode: start address, length and enable bit, written over the CPU bus.
module sfd_regs #(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          LEN_W       = 12,
   parameter int          EN_BIT      = 4,
   parameter logic [15:0] START_REG_A = 16'h4012,
   parameter logic [15:0] LEN_REG_A   = 16'h4013,
   parameter logic [15:0] CTRL_REG_A  = 16'h4015,
   parameter logic [15:0] START_BASE  = 16'hC000,
   parameter int          ADDR_STEP   = 64,
   parameter int          LEN_STEP    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    cpu_addr,
   input  logic             cpu_rw,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             en,
   output logic             load,
   output logic [AW-1:0]    start_addr,
   output logic [LEN_W-1:0] start_len
);

   logic [DW-1:0] start_q;
   logic [DW-1:0] len_q;
   logic          wr_start;
   logic          wr_len;
   logic          wr_ctrl;

   assign wr_start = !cpu_rw && (cpu_addr == AW'(START_REG_A));
   assign wr_len   = !cpu_rw && (cpu_addr == AW'(LEN_REG_A));
   assign wr_ctrl  = !cpu_rw && (cpu_addr == AW'(CTRL_REG_A));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         len_q   <= '0;
         en      <= 1'b0;
      end else begin
         if (wr_start) start_q <= cpu_wdata;
         if (wr_len)   len_q   <= cpu_wdata;
         if (wr_ctrl)  en      <= cpu_wdata[EN_BIT];
      end
   end

   assign load       = wr_ctrl && cpu_wdata[EN_BIT];
   assign start_addr = AW'(START_BASE) + AW'(start_q) * AW'(ADDR_STEP);
   assign start_len  = LEN_W'(len_q) * LEN_W'(LEN_STEP) + LEN_W'(1);

endmodule

// File: rtl/sfd_cursor.sv
// Sample cursor: current fetch address and remaining byte count.
module sfd_cursor #(
   parameter int AW    = 16,
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    start_addr,
   input  logic [LEN_W-1:0] start_len,
   input  logic             step,
   output logic [AW-1:0]    samp_addr,
   output logic [LEN_W-1:0] remain,
   output logic             has_more
);

   assign has_more = (remain != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_addr <= '0;
         remain    <= '0;
      end else if (load && !has_more) begin
         samp_addr <= start_addr;
         remain    <= start_len;
      end else if (step && has_more) begin
         samp_addr <= samp_addr + AW'(1);
         remain    <= remain - LEN_W'(1);
      end
   end

endmodule

// File: rtl/sfd_stall.sv
// Stall sequencer: holds ready low, counts read cycles, captures the byte.
module sfd_stall
   import sfd_pkg::*;
#(
   parameter int STALL_CYC = 4,
   parameter int DW        = 8,
   parameter bit OUT_REG   = 1'b1,
   localparam int CW       = $clog2(STALL_CYC),
   localparam int RPT_W    = $clog2(STALL_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             cpu_rw,
   input  logic [DW-1:0]    bus_rdata,
   output logic             rdy,
   output logic             cap,
   output logic             byte_valid,
   output logic [DW-1:0]    byte_data,
   output logic [RPT_W-1:0] rpt_cnt
);

   localparam logic [CW-1:0] LAST = CW'(STALL_CYC - 1);

   if (STALL_CYC < 2) begin : g_bad_stall
      $error("sfd_stall: STALL_CYC must be at least 2");
   end

   stall_st_e     st_q;
   logic [CW-1:0] cnt_q;
   logic          advance;

   assign rdy     = (st_q == ST_IDLE);
   assign cap     = (st_q == ST_STALL) && (cnt_q == LAST);
   assign advance = (cnt_q != '0) || cpu_rw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         rpt_cnt <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req) begin
                  st_q    <= ST_STALL;
                  cnt_q   <= '0;
                  rpt_cnt <= '0;
               end
            end
            ST_STALL: begin
               if (cap) begin
                  st_q  <= ST_IDLE;
                  cnt_q <= '0;
               end else if (advance) begin
                  cnt_q <= cnt_q + CW'(1);
               end
               if (cpu_rw && !cap) rpt_cnt <= rpt_cnt + RPT_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
         end else begin
            byte_valid <= cap;
            if (cap) byte_data <= bus_rdata;
         end
      end
   end else begin : g_out_comb
      assign byte_valid = cap;
      assign byte_data  = bus_rdata;
   end

endmodule

// File: rtl/sample_fetch_dma.sv
// Top: sample-fetch DMA that stalls the CPU through its ready input.
module sample_fetch_dma #(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          LEN_W       = 12,
   parameter int          STALL_CYC   = 4,
   parameter bit          OUT_REG     = 1'b1,
   parameter int          EN_BIT      = 4,
   parameter logic [15:0] START_REG_A = 16'h4012,
   parameter logic [15:0] LEN_REG_A   = 16'h4013,
   parameter logic [15:0] CTRL_REG_A  = 16'h4015,
   parameter logic [15:0] START_BASE  = 16'hC000,
   parameter int          ADDR_STEP   = 64,
   parameter int          LEN_STEP    = 16,
   localparam int         RPT_W       = $clog2(STALL_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    cpu_addr,
   input  logic             cpu_rw,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             cpu_rdy,
   output logic [AW-1:0]    bus_addr,
   output logic             bus_rw,
   input  logic [DW-1:0]    bus_rdata,
   input  logic             buf_empty,
   output logic             byte_valid,
   output logic [DW-1:0]    byte_data,
   output logic [RPT_W-1:0] rpt_cnt
);

   if (EN_BIT >= DW) begin : g_bad_en
      $error("sample_fetch_dma: EN_BIT outside the data width");
   end
   if (LEN_W < DW) begin : g_bad_len
      $error("sample_fetch_dma: LEN_W too narrow for the length register");
   end

   logic             en;
   logic             load;
   logic [AW-1:0]    start_addr;
   logic [LEN_W-1:0] start_len;
   logic [AW-1:0]    samp_addr;
   logic [LEN_W-1:0] remain;
   logic             has_more;
   logic             cap;
   logic             req;

   sfd_regs #(
      .AW(AW), .DW(DW), .LEN_W(LEN_W), .EN_BIT(EN_BIT),
      .START_REG_A(START_REG_A), .LEN_REG_A(LEN_REG_A), .CTRL_REG_A(CTRL_REG_A),
      .START_BASE(START_BASE), .ADDR_STEP(ADDR_STEP), .LEN_STEP(LEN_STEP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
      .cpu_wdata(cpu_wdata), .en(en), .load(load),
      .start_addr(start_addr), .start_len(start_len)
   );

   sfd_cursor #(.AW(AW), .LEN_W(LEN_W)) u_cursor (
      .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
      .start_len(start_len), .step(cap), .samp_addr(samp_addr),
      .remain(remain), .has_more(has_more)
   );

   assign req = en && has_more && buf_empty && !byte_valid;

   sfd_stall #(.STALL_CYC(STALL_CYC), .DW(DW), .OUT_REG(OUT_REG)) u_stall (
      .clk(clk), .rst_n(rst_n), .req(req), .cpu_rw(cpu_rw),
      .bus_rdata(bus_rdata), .rdy(cpu_rdy), .cap(cap),
      .byte_valid(byte_valid), .byte_data(byte_data), .rpt_cnt(rpt_cnt)
   );

   assign bus_addr = cap ? samp_addr : cpu_addr;
   assign bus_rw   = cap ? 1'b1 : cpu_rw;

endmodule

// File: rtl/sfd_chk.sv
// Checker bound to the top module.
module sfd_chk #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int LEN_W     = 12,
   parameter int RPT_W     = 3,
   parameter int STALL_CYC = 4,
   parameter bit OUT_REG   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_rdy,
   input logic [AW-1:0]    cpu_addr,
   input logic             cpu_rw,
   input logic [AW-1:0]    bus_addr,
   input logic             bus_rw,
   input logic [DW-1:0]    bus_rdata,
   input logic             buf_empty,
   input logic             cap,
   input logic             byte_valid,
   input logic [DW-1:0]    byte_data,
   input logic [AW-1:0]    samp_addr,
   input logic [LEN_W-1:0] remain,
   input logic [RPT_W-1:0] rpt_cnt
);

   // R10
   bus_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |-> (bus_addr == cpu_addr) && (bus_rw == cpu_rw));

   // R3
   no_req_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdy && !buf_empty) |=> cpu_rdy);

   // R7
   zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdy && remain == '0) |=> cpu_rdy);

   // R7
   cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (samp_addr == $past(samp_addr) + AW'(1)) &&
              (remain == $past(remain) - LEN_W'(1)));

   // R9
   rpt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_cnt <= RPT_W'(STALL_CYC - 1));

   if (OUT_REG) begin : g_valid_chk
      // R6
      cap_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cap |=> byte_valid && (byte_data == $past(bus_rdata)));
   end

endmodule

bind sample_fetch_dma sfd_chk #(
   .AW(AW), .DW(DW), .LEN_W(LEN_W), .RPT_W(RPT_W),
   .STALL_CYC(STALL_CYC), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_rdy(cpu_rdy), .cpu_addr(cpu_addr),
   .cpu_rw(cpu_rw), .bus_addr(bus_addr), .bus_rw(bus_rw),
   .bus_rdata(bus_rdata), .buf_empty(buf_empty), .cap(cap),
   .byte_valid(byte_valid), .byte_data(byte_data), .samp_addr(samp_addr),
   .remain(remain), .rpt_cnt(rpt_cnt)
);

// File: tb/sample_fetch_dma_bench.sv
`timescale 1ns/1ps
module sample_fetch_dma_bench;

   localparam logic [15:0] A_START = 16'h4012;
   localparam logic [15:0] A_LEN   = 16'h4013;
   localparam logic [15:0] A_CTRL  = 16'h4015;
   localparam logic [15:0] A_PAD   = 16'h4016;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cpu_addr;
   logic        cpu_rw;
   logic [7:0]  cpu_wdata;
   logic        cpu_rdy;
   logic [15:0] bus_addr;
   logic        bus_rw;
   logic [7:0]  bus_rdata;
   logic        buf_empty;
   logic        byte_valid;
   logic [7:0]  byte_data;
   logic [2:0]  rpt_cnt;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   assign bus_rdata = bus_addr[7:0] ^ bus_addr[15:8];

   sample_fetch_dma u_sample_fetch_dma (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
      .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .bus_addr(bus_addr),
      .bus_rw(bus_rw), .bus_rdata(bus_rdata), .buf_empty(buf_empty),
      .byte_valid(byte_valid), .byte_data(byte_data), .rpt_cnt(rpt_cnt)
   );

   function automatic logic [7:0] mem_of(logic [15:0] a);
      return a[7:0] ^ a[15:8];
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic reg_write(logic [15:0] a, logic [7:0] d);
      cpu_addr = a; cpu_rw = 1'b0; cpu_wdata = d;
      @(negedge clk);
      cpu_addr = A_PAD; cpu_rw = 1'b1;
   endtask

   // Holds the buffer empty and expects no stall for n cycles.
   task automatic idle_check(int n, string req);
      int lows = 0;
      buf_empty = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!cpu_rdy) lows++;
      end
      chk(req, "stall cycles while no fetch allowed", lows, 0);
      buf_empty = 1'b0;
   endtask

   // One fetch; the CPU issues 'writes' write cycles once the stall begins.
   task automatic run_fetch(int writes, logic [15:0] waddr, logic [7:0] wdat,
                            logic [15:0] exp_addr, string req);
      int low  = 0;
      int left = writes;
      bit got  = 1'b0;
      cpu_addr  = A_PAD; cpu_rw = 1'b1;
      buf_empty = 1'b1;
      for (int i = 0; i < 40 && !got; i++) begin
         @(negedge clk);
         if (!cpu_rdy) begin
            low++;
            if (low == writes + 4) begin
               chk("R6", {req, " fetch address on bus"}, bus_addr, exp_addr);
               chk("R6", {req, " fetch is a read"}, bus_rw, 1);
            end
            if (left > 0) begin
               cpu_addr = waddr; cpu_rw = 1'b0; cpu_wdata = wdat; left--;
            end else begin
               cpu_addr = A_PAD; cpu_rw = 1'b1;
            end
         end else if (low > 0) begin
            got = 1'b1;
            chk(writes > 0 ? "R5" : "R4", {req, " ready low cycles"}, low, writes + 4);
            chk("R6", {req, " byte strobe"}, byte_valid, 1);
            chk("R6", {req, " byte value"}, byte_data, mem_of(exp_addr));
            chk("R9", {req, " repeated read count"}, rpt_cnt, 3);
            buf_empty = 1'b0;
         end
      end
      if (!got) chk(req, "fetch completed", 0, 1);
      @(negedge clk);
      chk("R6", {req, " strobe lasts one cycle"}, byte_valid, 0);
   endtask

   task automatic test_reset();
      rst_n = 1'b0; cpu_addr = 16'h1234; cpu_rw = 1'b1; cpu_wdata = '0;
      buf_empty = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "ready in reset", cpu_rdy, 1);
      chk("R1", "strobe in reset", byte_valid, 0);
      chk("R1", "repeat count in reset", rpt_cnt, 0);
      chk("R10", "address pass in reset", bus_addr, 16'h1234);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", cpu_rdy, 1);
   endtask

   task automatic test_disabled();
      idle_check(12, "R3 disabled");
      reg_write(A_CTRL, 8'hEF);
      idle_check(12, "R3 bit4 clear");
   endtask

   task automatic test_passthrough();
      buf_empty = 1'b0;
      cpu_addr = 16'h0300; cpu_rw = 1'b0; cpu_wdata = 8'h11;
      @(negedge clk);
      chk("R10", "write address passes", bus_addr, 16'h0300);
      chk("R10", "write type passes", bus_rw, 0);
      cpu_addr = A_PAD; cpu_rw = 1'b1;
      @(negedge clk);
   endtask

   task automatic test_single_byte();
      buf_empty = 1'b0;
      reg_write(A_START, 8'h02);
      reg_write(A_LEN, 8'h00);
      reg_write(A_CTRL, 8'h10);
      run_fetch(0, 16'h0000, 8'h00, 16'hC080, "R2 R4 single");
      idle_check(12, "R7 count exhausted");
   endtask

   task automatic test_sequence();
      buf_empty = 1'b0;
      reg_write(A_START, 8'h03);
      reg_write(A_LEN, 8'h01);
      reg_write(A_CTRL, 8'h10);
      run_fetch(0, 16'h0000, 8'h00, 16'hC0C0, "R2 reload");
      run_fetch(2, 16'h0300, 8'h55, 16'hC0C1, "R5 R7 writes");
      run_fetch(1, A_CTRL, 8'h00, 16'hC0C2, "R8 disable in stall");
      idle_check(12, "R8 after disable");
      reg_write(A_CTRL, 8'h10);
      run_fetch(0, 16'h0000, 8'h00, 16'hC0C3, "R2 keep position");
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end

   initial begin
      test_reset();
      test_disabled();
      test_passthrough();
      test_single_byte();
      test_sequence();
      done = 1'b1;
      summary();
   end

endmodule